// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Readout Master

This block is the host side of the serial link to a multi-channel delta-sigma converter. When a start request arrives, it lowers chip select and watches the converter's data line. That line stays high while a conversion is still running. Once the line goes low, the block runs one framed transfer of exactly 32 serial clocks.

During that frame the block shifts out a command word. The command selects the input channel, the oversampling ratio and the speed mode of the *next* conversion. In the same frame it shifts in the 32-bit result of the conversion that just finished. It then splits the captured word into a sign bit and 29 data bits and pulses a valid strobe. Alongside the result it reports the configuration that produced it, so each output word maps one-to-one to the command that set up its conversion.

The serial clock comes from the system clock through a programmable divider and idles low. A frame can be cut short by an abort request. If the converter never reports ready, the block gives up after a programmable number of polls and flags an error.

Top module: `dsadc_reader`

## Requirements
- R1: Out of reset, chip select is high, the serial clock is low, and both the valid and error strobes are low. The configuration reported with the first completed result is the power-up default: channel pair 0, oversampling code 3 (ratio 256), single speed. In the 10-bit configuration layout this is 0x006. The layout is: bit 9 single-ended, bit 8 odd/sign select, bits 7:5 address, bits 4:1 oversampling code, bit 0 double speed.
- R2: On a start request, chip select goes low and the data line is polled once per system clock. No serial clock edge is produced while the data line reads high.
- R3: If the data line is still high on the poll where the poll counter has reached `timeout_i`, the following happens together: `timeout_err_o` pulses for one clock, chip select returns high, and no serial clock or valid strobe is produced.
- R4: The serial clock stays high for `div_i` system clocks and low for `div_i` system clocks, so its period is 2·`div_i`. A value of 0 is treated as 1.
- R5: A completed frame contains exactly 32 rising serial clock edges. Chip select returns high on the falling edge that follows the 32nd rising edge.
- R6: The first 13 bits on SDI, MSB first, are: 1, 0, 1, then the 10-bit configuration latched at the start request (in the R1 layout). SDI changes only while the serial clock is low.
- R7: SDI is low at rising edges 14 through 32.
- R8: SDO is sampled on each rising edge, first bit first. `result_o` equals bits 28:0 of the captured word and `sign_o` equals bit 29.
- R9: After a completed frame, `result_valid_o` is high for exactly one system clock, in the same cycle that chip select rises. `result_cfg_o` then shows the configuration that was sent on the previous completed frame.
- R10: An abort request during a frame raises chip select during a low phase of the serial clock and returns the block to idle. No valid strobe is produced, and the configuration tracking is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a readout (taken when idle) |
| abort_i | input | 1 | Cut the current frame short |
| cfg_i | input | 10 | Configuration for the next conversion (R1 layout) |
| div_i | input | DIV_W | Serial clock half period in system clocks |
| timeout_i | input | TMO_W | Poll count limit before giving up |
| adc_cs_n_o | output | 1 | Chip select, active low |
| adc_sck_o | output | 1 | Serial clock, idles low |
| adc_sdi_o | output | 1 | Command data to the converter |
| adc_sdo_i | input | 1 | Ready flag and result data from the converter |
| result_valid_o | output | 1 | One-clock strobe for a completed result |
| result_o | output | 29 | Result data bits |
| sign_o | output | 1 | Result sign bit |
| result_cfg_o | output | 10 | Configuration that produced this result |
| timeout_err_o | output | 1 | One-clock strobe when polling gives up |

## Verification
A behavioural converter model returns chosen 32-bit words and records every SDI bit. Each returned word has a distinct sign and an alternating data pattern, so a swapped, shifted or misaligned capture shows up as a wrong value. The frames are run under two divider settings, with an immediate ready and with a long busy period, and with four different configurations. These cases separate correct clock timing, correct polling and the one-frame lag between command and result tag. An aborted frame followed by a normal frame shows that the abort leaves no strobe behind and does not disturb the tracked configuration. A converter held permanently busy exercises the timeout path.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

    localparam int FRAME_BITS = 32;
    localparam int CFG_W      = 10;
    localparam int CMD_BITS   = CFG_W + 3;
    localparam int DATA_W     = FRAME_BITS - 3;
    localparam int SIGN_POS   = DATA_W;

    typedef struct packed {
        logic       single;
        logic       odd;
        logic [2:0] addr;
        logic [3:0] osr;
        logic       dbl;
    } cfg_t;

    localparam cfg_t CFG_DEFAULT = '{single: 1'b0, odd: 1'b0, addr: 3'd0,
                                     osr: 4'd3, dbl: 1'b0};

    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_POLL  = 2'd1,
        RD_SHIFT = 2'd2
    } rd_state_e;

    // Command: start pattern 1,0 then enable, then the configuration fields.
    function automatic logic [CMD_BITS-1:0] make_cmd(input cfg_t c);
        return {2'b10, 1'b1, c};
    endfunction

endpackage

// File: rtl/dsr_sck_gen.sv
module dsr_sck_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             sck_o,
    output logic             rise_o,
    output logic             fall_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             sck;
    } gen_t;

    gen_t             q, d;
    logic [DIV_W-1:0] div_eff;
    logic             tick;

    always_comb begin
        div_eff = (div_i == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : div_i;
        tick    = run_i && (q.cnt == div_eff - 1'b1);
        d       = q;
        if (!run_i) begin
            d.cnt = '0;
            d.sck = 1'b0;
        end else if (tick) begin
            d.cnt = '0;
            d.sck = ~q.sck;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sck_o  = q.sck;
    assign rise_o = tick && !q.sck;
    assign fall_o = tick && q.sck;

endmodule

// File: rtl/dsr_shifter.sv
module dsr_shifter
    import dsr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic [CMD_BITS-1:0]   cmd_i,
    input  logic                  shift_i,
    input  logic                  capture_i,
    input  logic                  sdo_i,
    output logic                  sdi_o,
    output logic [FRAME_BITS-1:0] word_o
);

    localparam int PAD_W = FRAME_BITS - CMD_BITS;

    typedef struct packed {
        logic [FRAME_BITS-1:0] tx;
        logic [FRAME_BITS-1:0] rx;
    } shf_t;

    shf_t q, d;

    always_comb begin
        d = q;
        if (load_i) begin
            d.tx = {cmd_i, {PAD_W{1'b0}}};
            d.rx = '0;
        end else begin
            if (shift_i) begin
                d.tx = {q.tx[FRAME_BITS-2:0], 1'b0};
            end
            if (capture_i) begin
                d.rx = {q.rx[FRAME_BITS-2:0], sdo_i};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sdi_o  = q.tx[FRAME_BITS-1];
    assign word_o = q.rx;

endmodule

// File: rtl/dsadc_reader.sv
module dsadc_reader
    import dsr_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int TMO_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              abort_i,
    input  logic [CFG_W-1:0]  cfg_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [TMO_W-1:0]  timeout_i,
    output logic              adc_cs_n_o,
    output logic              adc_sck_o,
    output logic              adc_sdi_o,
    input  logic              adc_sdo_i,
    output logic              result_valid_o,
    output logic [DATA_W-1:0] result_o,
    output logic              sign_o,
    output logic [CFG_W-1:0]  result_cfg_o,
    output logic              timeout_err_o
);

    localparam int CNT_W = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS);

    typedef struct packed {
        rd_state_e         st;
        logic              cs_n;
        cfg_t              cur;
        cfg_t              pend;
        logic [TMO_W-1:0]  tmo;
        logic [CNT_W-1:0]  bits;
        logic              abort_pend;
        logic              valid;
        logic              err;
        logic [DATA_W-1:0] res;
        logic              sign;
        cfg_t              res_cfg;
    } rd_t;

    rd_t                   q, d;
    logic                  run, load, abort_now;
    logic                  sck, rise, fall;
    logic [FRAME_BITS-1:0] word;

    dsr_sck_gen #(.DIV_W(DIV_W)) sck_gen_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .div_i  (div_i),
        .sck_o  (sck),
        .rise_o (rise),
        .fall_o (fall)
    );

    dsr_shifter shifter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .cmd_i     (make_cmd(q.pend)),
        .shift_i   (fall),
        .capture_i (rise),
        .sdo_i     (adc_sdo_i),
        .sdi_o     (adc_sdi_o),
        .word_o    (word)
    );

    always_comb begin
        d         = q;
        d.valid   = 1'b0;
        d.err     = 1'b0;
        run       = 1'b0;
        load      = 1'b0;
        abort_now = 1'b0;
        unique case (q.st)
            RD_IDLE: begin
                if (start_i) begin
                    d.st         = RD_POLL;
                    d.cs_n       = 1'b0;
                    d.pend       = cfg_t'(cfg_i);
                    d.tmo        = '0;
                    d.abort_pend = 1'b0;
                end
            end
            RD_POLL: begin
                if (abort_i) begin
                    d.st   = RD_IDLE;
                    d.cs_n = 1'b1;
                end else if (!adc_sdo_i) begin
                    d.st   = RD_SHIFT;
                    d.bits = '0;
                    load   = 1'b1;
                end else if (q.tmo == timeout_i) begin
                    d.st   = RD_IDLE;
                    d.cs_n = 1'b1;
                    d.err  = 1'b1;
                end else begin
                    d.tmo = q.tmo + 1'b1;
                end
            end
            RD_SHIFT: begin
                abort_now    = (abort_i || q.abort_pend) && !sck;
                run          = !abort_now;
                d.abort_pend = q.abort_pend || abort_i;
                if (abort_now) begin
                    d.st         = RD_IDLE;
                    d.cs_n       = 1'b1;
                    d.abort_pend = 1'b0;
                end else if (rise) begin
                    d.bits = q.bits + 1'b1;
                end else if (fall && q.bits == LAST_BIT) begin
                    d.st      = RD_IDLE;
                    d.cs_n    = 1'b1;
                    d.valid   = 1'b1;
                    d.res     = word[DATA_W-1:0];
                    d.sign    = word[SIGN_POS];
                    d.res_cfg = q.cur;
                    d.cur     = q.pend;
                end
            end
            default: begin
                d.st   = RD_IDLE;
                d.cs_n = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.st      <= RD_IDLE;
            q.cs_n    <= 1'b1;
            q.cur     <= CFG_DEFAULT;
            q.pend    <= CFG_DEFAULT;
            q.res_cfg <= CFG_DEFAULT;
        end else begin
            q <= d;
        end
    end

    assign adc_cs_n_o     = q.cs_n;
    assign adc_sck_o      = sck;
    assign result_valid_o = q.valid;
    assign result_o       = q.res;
    assign sign_o         = q.sign;
    assign result_cfg_o   = q.res_cfg;
    assign timeout_err_o  = q.err;

endmodule

// File: rtl/dsadc_reader_chk.sv
module dsadc_reader_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             sck,
    input logic             sdi,
    input logic             valid,
    input logic             err,
    input logic [DIV_W-1:0] div
);

    logic [DIV_W-1:0] hi_cnt;
    logic [DIV_W-1:0] div_eff;

    assign div_eff = (div == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : div;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (sck) begin
            hi_cnt <= hi_cnt + 1'b1;
        end else begin
            hi_cnt <= '0;
        end
    end

    // R1
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    // R4
    sck_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sck) |-> (hi_cnt == div_eff));

    // R6
    sdi_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdi) |-> !sck);

    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R9
    valid_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $rose(cs_n));

    // R3
    err_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (cs_n && !valid));

endmodule

bind dsadc_reader dsadc_reader_chk #(.DIV_W(DIV_W)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (adc_cs_n_o),
    .sck   (adc_sck_o),
    .sdi   (adc_sdi_o),
    .valid (result_valid_o),
    .err   (timeout_err_o),
    .div   (div_i)
);

// File: tb/dsadc_reader_tb.sv
`timescale 1ns/1ps
module dsadc_reader_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        abort = 1'b0;
    logic [9:0]  cfg_in = 10'h000;
    logic [7:0]  div = 8'd2;
    logic [15:0] tmo = 16'd1000;
    logic        cs_n, sck, sdi, sdo, valid, sign, err;
    logic [28:0] res;
    logic [9:0]  res_cfg;

    always #2 clk = ~clk;

    dsadc_reader dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start),
        .abort_i        (abort),
        .cfg_i          (cfg_in),
        .div_i          (div),
        .timeout_i      (tmo),
        .adc_cs_n_o     (cs_n),
        .adc_sck_o      (sck),
        .adc_sdi_o      (sdi),
        .adc_sdo_i      (sdo),
        .result_valid_o (valid),
        .result_o       (res),
        .sign_o         (sign),
        .result_cfg_o   (res_cfg),
        .timeout_err_o  (err)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // ---------------- converter model ----------------
    int          cyc = 0;
    int          busy_until = 0;
    bit          stuck = 1'b0;
    bit          aborting = 1'b0;
    logic [31:0] model_word = 32'h0;
    logic [12:0] exp_cmd = 13'h0;
    logic [12:0] cap = 13'h0;
    bit          tail_bad = 1'b0;
    int          fall_cnt = 0;
    int          rise_cnt = 0;
    int          busy_rises = 0;
    longint      last_rise_t = 0;
    longint      period_ns = 0;

    always @(posedge clk) cyc <= cyc + 1;

    wire model_busy = stuck || (cyc < busy_until);
    assign sdo = cs_n ? 1'b1 : (model_busy ? 1'b1 :
                 ((fall_cnt < 32) ? model_word[31 - fall_cnt] : 1'b0));

    always @(negedge sck or posedge cs_n) begin
        if (cs_n) fall_cnt <= 0;
        else      fall_cnt <= fall_cnt + 1;
    end

    always @(posedge sck or posedge cs_n) begin
        if (cs_n) begin
            if (rise_cnt > 0 && !aborting) begin
                chk(rise_cnt == 32, "R5 rising edges per frame", rise_cnt, 32);
                if (rise_cnt == 32) begin
                    chk(cap == exp_cmd, "R6 command word", cap, exp_cmd);
                    chk(!tail_bad, "R7 SDI low after command", tail_bad, 0);
                end
            end
            rise_cnt = 0;
            tail_bad = 1'b0;
        end else begin
            if (model_busy) busy_rises++;
            if (rise_cnt > 0) period_ns = $time - last_rise_t;
            last_rise_t = $time;
            if (rise_cnt < 13) cap = {cap[11:0], sdi};
            else if (sdi) tail_bad = 1'b1;
            rise_cnt = rise_cnt + 1;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [28:0] res;
        logic        sign;
        logic [9:0]  tag;
    } exp_t;

    exp_t       exp_q[$];
    logic [9:0] last_cfg = 10'h006;
    int         frames_done = 0;

    always @(negedge clk) begin
        if (rst_n && valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected result strobe", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(res == e.res, "R8 result data", res, e.res);
                chk(sign == e.sign, "R8 sign bit", sign, e.sign);
                chk(res_cfg == e.tag, "R9 R1 result configuration tag", res_cfg, e.tag);
            end
            frames_done++;
        end
    end

    task automatic run_frame(input logic [9:0] c, input logic [31:0] w, input int busy_len);
        exp_t e;
        int target;
        e.res  = w[28:0];
        e.sign = w[29];
        e.tag  = last_cfg;
        exp_q.push_back(e);
        last_cfg   = c;
        exp_cmd    = {3'b101, c};
        model_word = {2'b00, w[29:0]};
        target     = frames_done + 1;
        @(negedge clk);
        busy_until = cyc + busy_len;
        cfg_in = c;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (frames_done < target) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cs_n == 1'b1, "R1 chip select idle", cs_n, 1);
        chk(sck == 1'b0, "R1 clock idle", sck, 0);
        chk(valid == 1'b0, "R1 valid idle", valid, 0);
        chk(err == 1'b0, "R1 error idle", err, 0);

        div = 8'd2;
        run_frame(10'h3D5, 32'h2AAA_AAAA, 0);
        run_frame(10'h12A, 32'h1555_5555, 40);
        // R2 no clocking while busy
        chk(busy_rises == 0, "R2 no SCK while busy", busy_rises, 0);

        div = 8'd3;
        run_frame(10'h0F1, 32'h3000_0F0F, 5);
        // R4 period
        chk(period_ns == 24, "R4 SCK period for div 3", period_ns, 24);

        // R10 abort mid-frame
        begin
            int saw_rises;
            bit sck_at_rel;
            int base;
            aborting = 1'b1;
            base = frames_done;
            model_word = 32'h0123_4567;
            @(negedge clk);
            busy_until = cyc;
            cfg_in = 10'h2FF;
            start  = 1'b1;
            @(negedge clk);
            start = 1'b0;
            while (rise_cnt < 10) @(negedge clk);
            abort = 1'b1;
            @(negedge clk);
            abort = 1'b0;
            saw_rises = rise_cnt;
            for (int i = 0; i < 50 && !cs_n; i++) @(negedge clk);
            sck_at_rel = sck;
            chk(cs_n == 1'b1, "R10 chip select released", cs_n, 1);
            chk(sck_at_rel == 1'b0, "R10 release in low phase", sck_at_rel, 0);
            chk(saw_rises < 32, "R10 frame cut short", saw_rises, 31);
            repeat (30) @(negedge clk);
            chk(frames_done == base, "R10 no result after abort", frames_done, base);
            aborting = 1'b0;
        end
        // R10 tag unchanged by abort: next tag is still 0x0F1
        run_frame(10'h000, 32'h3FFF_FFFF, 0);

        // R3 timeout
        begin
            int waited;
            bit seen;
            seen = 1'b0;
            waited = 0;
            tmo = 16'd20;
            stuck = 1'b1;
            @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            for (int i = 0; i < 60 && !seen; i++) begin
                if (err) seen = 1'b1;
                else begin
                    waited++;
                    @(negedge clk);
                end
            end
            chk(seen, "R3 timeout flagged", seen, 1);
            chk(waited >= 20 && waited <= 24, "R3 timeout delay", waited, 21);
            chk(cs_n == 1'b1, "R3 chip select released", cs_n, 1);
            @(negedge clk);
            chk(err == 1'b0, "R3 error is one pulse", err, 0);
            stuck = 1'b0;
            chk(busy_rises == 0, "R2 R3 no SCK while busy", busy_rises, 0);
        end
        chk(exp_q.size() == 0, "R9 all results delivered", exp_q.size(), 0);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule